// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

This block stores a word of configurable width, four bits by default. On every rising clock edge it does exactly one of four things, chosen by a two-bit mode input: keep the word, move it one place toward the least significant end, move it one place toward the most significant end, or replace it with a parallel input word. Each shift direction has its own serial input, so a right shift can fill the top bit from one source while a left shift fills the bottom bit from another. The stored word is always visible on the parallel output.

A synchronous active-high reset clears the word and overrides any mode. The design is strictly edge-triggered, so data moves exactly one stage per clock no matter how long the clock stays high. The width parameter must be at least 2.

Top module: `uni_shifter`

## Requirements
- R1: When `rst` is high at a rising edge, every stored bit becomes 0 after that edge, whatever `mode` is set to.
- R2: With `mode` = 2'b00 the stored word is unchanged by the edge.
- R3: With `mode` = 2'b01 the word moves one place right: bit i takes the old bit i+1, the top bit takes `serRight`, and the old bit 0 is dropped.
- R4: With `mode` = 2'b10 the word moves one place left: bit i takes the old bit i-1, bit 0 takes `serLeft`, and the old top bit is dropped.
- R5: With `mode` = 2'b11 the word takes the value of `parIn` after the edge.
- R6: Inputs that the current mode does not use have no effect: `parIn` outside load, `serLeft` outside left shift, `serRight` outside right shift; each edge moves data by exactly one stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to all zeros |
| mode | input | 2 | Operation select: 00 hold, 01 right, 10 left, 11 load |
| serRight | input | 1 | Serial bit entering the top bit on a right shift |
| serLeft | input | 1 | Serial bit entering bit 0 on a left shift |
| parIn | input | WIDTH | Word taken on a load |
| parOut | output | WIDTH | Stored word |

## Verification
Reset and a mode operation can fall on the same edge; the bench asserts reset while the mode selects a load of a nonzero word or a shift with a 1 at the serial input, and expects zeros afterwards. The second overlap is a mode change on consecutive edges, where one edge's shift must start from the previous edge's result; random mode sequences with no idle cycles provoke it, and a behavioural bit-queue model compares the whole word after every edge.

// File: rtl/uni_shifter_pkg.sv
package uni_shifter_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP  = 2'b00,
    MODE_RIGHT = 2'b01,
    MODE_LEFT  = 2'b10,
    MODE_LOAD  = 2'b11
  } shift_mode_e;

  typedef struct packed {
    logic clear;
    logic keep;
    logic goRight;
    logic goLeft;
    logic load;
  } shift_strobes_t;

endpackage

// File: rtl/uni_shifter_ctrl.sv
module uni_shifter_ctrl
  import uni_shifter_pkg::*;
(
  input  logic           rst,
  input  logic [1:0]     modeSel,
  output shift_strobes_t strobes
);

  shift_mode_e modeDec;
  assign modeDec = shift_mode_e'(modeSel);

  always_comb begin
    strobes = '0;
    if (rst) begin
      strobes.clear = 1'b1;
    end else begin
      unique case (modeDec)
        MODE_KEEP:  strobes.keep    = 1'b1;
        MODE_RIGHT: strobes.goRight = 1'b1;
        MODE_LEFT:  strobes.goLeft  = 1'b1;
        MODE_LOAD:  strobes.load    = 1'b1;
        default:    strobes.keep    = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/uni_shifter_dp.sv
module uni_shifter_dp
  import uni_shifter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  shift_strobes_t   strobes,
  input  logic             serRight,
  input  logic             serLeft,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] word
);

  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] nextWord;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic fromAbove;
    logic fromBelow;

    if (i == TOP) begin : g_top
      assign fromAbove = serRight;
    end else begin : g_mid_hi
      assign fromAbove = word[i+1];
    end

    if (i == 0) begin : g_bottom
      assign fromBelow = serLeft;
    end else begin : g_mid_lo
      assign fromBelow = word[i-1];
    end

    always_comb begin
      nextWord[i] = word[i];
      if (strobes.clear)        nextWord[i] = 1'b0;
      else if (strobes.goRight) nextWord[i] = fromAbove;
      else if (strobes.goLeft)  nextWord[i] = fromBelow;
      else if (strobes.load)    nextWord[i] = parIn[i];
    end
  end

  always_ff @(posedge clk) begin
    word <= nextWord;
  end

  // R2
  a_r2_keep_stable: assert property (@(posedge clk) disable iff (rst)
    strobes.keep |=> $stable(word));

  // R3
  a_r3_right_move: assert property (@(posedge clk) disable iff (rst)
    strobes.goRight |=> word == {$past(serRight), $past(word[TOP:1])});

  // R4
  a_r4_left_move: assert property (@(posedge clk) disable iff (rst)
    strobes.goLeft |=> word == {$past(word[TOP-1:0]), $past(serLeft)});

  // R5
  a_r5_load_take: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> word == $past(parIn));

endmodule

// File: rtl/uni_shifter.sv
module uni_shifter
  import uni_shifter_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode,
  input  logic             serRight,
  input  logic             serLeft,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] parOut
);

  shift_strobes_t strobes;

  uni_shifter_ctrl u_ctrl (
    .rst     (rst),
    .modeSel (mode),
    .strobes (strobes)
  );

  uni_shifter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .serRight (serRight),
    .serLeft  (serLeft),
    .parIn    (parIn),
    .word     (parOut)
  );

  // R1
  a_r1_reset_zero: assert property (@(posedge clk)
    rst |=> parOut == '0);

  // R6: exactly one strobe per edge
  a_r6_one_op: assert property (@(posedge clk)
    $countones(strobes) == 1);

endmodule

// File: tb/tb_uni_shifter.sv
module tb_uni_shifter;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst;
  logic [1:0]   mode;
  logic         serRight;
  logic         serLeft;
  logic [W-1:0] parIn;
  logic [W-1:0] parOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  bit model[$];   // index 0 = bit 0

  uni_shifter #(.WIDTH(W)) dut (
    .clk(clk), .rst(rst), .mode(mode),
    .serRight(serRight), .serLeft(serLeft),
    .parIn(parIn), .parOut(parOut)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic logic [W-1:0] modelWord();
    logic [W-1:0] v;
    for (int i = 0; i < W; i++) v[i] = model[i];
    return v;
  endfunction

  task automatic check(input string req);
    logic [W-1:0] exp;
    exp = modelWord();
    checks++;
    if (parOut !== exp) begin
      fails++;
      $display("FAIL %s: actual=%b expected=%b", req, parOut, exp);
    end
  endtask

  // drive at negedge, model updates at the edge, compare at next negedge
  task automatic step(input logic r, input logic [1:0] m, input logic sr,
                      input logic sl, input logic [W-1:0] pi, input string req);
    rst = r; mode = m; serRight = sr; serLeft = sl; parIn = pi;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < W; i++) model[i] = 1'b0;
    end else begin
      case (m)
        2'b01: begin void'(model.pop_front()); model.push_back(sr); end
        2'b10: begin void'(model.pop_back()); model.push_front(sl); end
        2'b11: for (int i = 0; i < W; i++) model[i] = pi[i];
        default: ;
      endcase
    end
    @(negedge clk);
    check(req);
  endtask

  function automatic string reqOf(input logic [1:0] m);
    case (m)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < W; i++) model.push_back(1'b0);
    rst = 1'b1; mode = 2'b00; serRight = 1'b0; serLeft = 1'b0; parIn = '0;
    @(negedge clk);
    step(1'b1, 2'b00, 1'b0, 1'b0, '0, "R1 reset state");
    // R1: reset beats load and shift with ones
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1011, "R5 load");
    step(1'b1, 2'b11, 1'b1, 1'b1, 4'b1111, "R1 reset over load");
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0110, "R5 load");
    step(1'b1, 2'b01, 1'b1, 1'b1, 4'b1111, "R1 reset over shift");
    // R2 hold with noisy unused inputs (R6)
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1001, "R5 load");
    step(1'b0, 2'b00, 1'b1, 1'b1, 4'b0110, "R2/R6 hold ignores inputs");
    step(1'b0, 2'b00, 1'b0, 1'b1, 4'b1111, "R2/R6 hold ignores inputs");
    // R3 right fill with ones, serLeft=0 ignored
    for (int k = 0; k < W; k++)
      step(1'b0, 2'b01, 1'b1, 1'b0, 4'b0000, "R3/R6 right fill");
    // R4 left fill with zeros, serRight=1 ignored
    for (int k = 0; k < W; k++)
      step(1'b0, 2'b10, 1'b1, 1'b0, 4'b1111, "R4/R6 left fill");
    // R3 drops bit 0, R4 drops top bit
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b0001, "R5 load");
    step(1'b0, 2'b01, 1'b0, 1'b1, 4'b1111, "R3 lsb dropped");
    step(1'b0, 2'b11, 1'b0, 1'b0, 4'b1000, "R5 load");
    step(1'b0, 2'b10, 1'b1, 1'b0, 4'b1111, "R4 msb dropped");
    // back-to-back random modes, R6 one stage per edge
    for (int k = 0; k < 400; k++) begin
      logic [1:0] m;
      logic r;
      m = 2'($urandom_range(0, 3));
      r = ($urandom_range(0, 39) == 0);
      step(r, m, 1'($urandom), 1'($urandom), W'($urandom),
           r ? "R1 random" : reqOf(m));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule